// File: doc/BRIEF.md
# Dual-Port DAC Sample Interleaver

This block feeds a high-speed converter from two 14-bit sample ports, A and B. The block's clock `clk` runs at the output word rate. One input cycle spans two clocks. At the input-cycle boundary the block registers one word from each port and the selected ordering mode. Over the next two clocks it then emits a pair of output words, first and then second. The pair goes out one word per clock on a serial lane, which can feed a 2x-rate serializer. The same pair is also held on a two-lane output for the whole pair, with a phase flag that marks which word the serial lane is carrying.

Four one-hot mode inputs pick the ordering:
- Plain alternation: A then B.
- Repeat: A then A.
- Negate: A then the mirror image of A about midscale.
- Zero-stuff: A then the midscale code.

Samples are offset binary. All ones is full positive output, all zeros is full negative output, and 14'h2000 is zero. An active-high sleep input parks the outputs at midscale and stops the input registers from loading.

The sequencing is a three-state machine:
- IDLE: outputs at midscale. Entered at reset and on sleep.
- FIRST: the first word of a pair is on the serial lane.
- SECOND: the second word is on the serial lane.

Transitions:
- IDLE→FIRST when sleep is low. This loads a pair.
- IDLE→IDLE while sleep is high.
- FIRST→SECOND always.
- SECOND→FIRST when sleep is low. This loads the next pair.
- SECOND→IDLE when sleep is high.

Top module: `dac_interleaver`

## Requirements
- R1: While reset is asserted and right after its release, `ser_data`, `lane_first` and `lane_second` equal midscale 14'h2000, and `lane_valid` and `ser_second` are 0.
- R2: Alternation mode (`sel_alt` the only mode input high) gives the pair (A, B).
- R3: Repeat mode (`sel_repeat` the only one high) gives the pair (A, A). Port B has no effect on any output.
- R4: Negate mode (`sel_negate` the only one high) gives (A, ~A), the bitwise complement of the 14-bit word. Examples: 14'h0000 pairs with 14'h3FFF, and 14'h2000 pairs with 14'h1FFF.
- R5: Zero-stuff mode (`sel_stuff` the only one high) gives (A, 14'h2000).
- R6: If no mode input is high, or more than one is high, the block uses alternation mode.
- R7: Inputs are registered at the rising edge that ends a cycle with `take_input` high. The first word appears on `ser_data` in the next clock with `ser_second`=0. The second word follows in the clock after that with `ser_second`=1.
- R8: `lane_first` and `lane_second` carry the first and second word of the current pair, and `lane_valid` is 1, throughout both clocks of the pair.
- R9: Port data and mode inputs that change between the first and second word of a pair have no effect on that pair.
- R10: Sleep is acted on only at an input-cycle boundary. While asleep, `ser_data` and both lanes sit at midscale, `lane_valid` is 0, and nothing is loaded. After sleep drops, the next rising edge loads a new pair.
- R11: `take_input` is 1 exactly in the clocks whose closing edge loads a pair: not asleep, and either idle or showing the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output word-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_a | input | 14 | Port A sample, offset binary |
| port_b | input | 14 | Port B sample, offset binary |
| sel_alt | input | 1 | Mode select: alternate A and B |
| sel_repeat | input | 1 | Mode select: repeat A |
| sel_negate | input | 1 | Mode select: A then its complement |
| sel_stuff | input | 1 | Mode select: A then midscale |
| sleep | input | 1 | Active-high sleep |
| take_input | output | 1 | The coming edge loads the ports |
| ser_data | output | 14 | Serial word, one per clock |
| ser_second | output | 1 | Phase flag: 1 while the second word is shown |
| lane_first | output | 14 | First word of the current pair |
| lane_second | output | 14 | Second word of the current pair |
| lane_valid | output | 1 | A pair is on the lanes |

## Verification
A phase machine that slips or sticks shows up at once as a `ser_second` or `take_input` value that is wrong in the very next clock. It also leaves a loaded pair on the serial lane for the wrong number of clocks. A wrong mode decode or pair builder corrupts the second word one clock after the first word. A capture register that loads mid-pair changes the lanes between the two clocks of a pair, so junk driven during the first word exposes it within one clock. Sleep handling is visible as a non-midscale word or a raised `lane_valid` in the first idle clock.

// File: rtl/dil_pkg.sv
`timescale 1ns/1ps
package dil_pkg;
    // Ordering mode picked at each input-cycle boundary
    typedef enum logic [1:0] {
        MODE_ALT    = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_NEGATE = 2'd2,
        MODE_STUFF  = 2'd3
    } mode_e;

    // Phase of the output pair
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    localparam int NUM_MODES = 4;
endpackage

// File: rtl/dil_mode_decode.sv
`timescale 1ns/1ps
module dil_mode_decode
    import dil_pkg::*;
(
    input  logic [NUM_MODES-1:0] sel,
    output mode_e                mode
);
    // Exactly one select high picks its mode; anything else falls back to alternation
    logic [$clog2(NUM_MODES+1)-1:0] high_count;
    logic                           one_hot;

    always_comb begin
        high_count = '0;
        for (int i = 0; i < NUM_MODES; i++) begin
            high_count = high_count + {{($bits(high_count)-1){1'b0}}, sel[i]};
        end
        one_hot = (high_count == 1);
    end

    always_comb begin
        mode = MODE_ALT;
        if (one_hot) begin
            unique case (1'b1)
                sel[0]:  mode = MODE_ALT;
                sel[1]:  mode = MODE_REPEAT;
                sel[2]:  mode = MODE_NEGATE;
                sel[3]:  mode = MODE_STUFF;
                default: mode = MODE_ALT;
            endcase
        end
    end
endmodule

// File: rtl/dil_pair_gen.sv
`timescale 1ns/1ps
module dil_pair_gen
    import dil_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    input  mode_e        mode,
    output logic [W-1:0] first_word,
    output logic [W-1:0] second_word
);
    // Offset binary: midscale is the top bit alone, mirror image is the complement
    localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

    assign first_word = a_word;

    always_comb begin
        unique case (mode)
            MODE_ALT:    second_word = b_word;
            MODE_REPEAT: second_word = a_word;
            MODE_NEGATE: second_word = ~a_word;
            MODE_STUFF:  second_word = MIDSCALE;
            default:     second_word = b_word;
        endcase
    end
endmodule

// File: rtl/dil_phase_fsm.sv
`timescale 1ns/1ps
module dil_phase_fsm
    import dil_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep,
    output phase_e phase,
    output logic   capture
);
    phase_e phase_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Transitions; sleep is only looked at on a pair boundary
    always_comb begin
        phase_nxt = phase;
        capture   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (!sleep) begin
                    phase_nxt = PH_FIRST;
                    capture   = 1'b1;
                end
            end
            PH_FIRST: begin
                phase_nxt = PH_SECOND;
            end
            PH_SECOND: begin
                if (sleep) begin
                    phase_nxt = PH_IDLE;
                end else begin
                    phase_nxt = PH_FIRST;
                    capture   = 1'b1;
                end
            end
            default: begin
                phase_nxt = PH_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/dac_interleaver.sv
`timescale 1ns/1ps
module dac_interleaver
    import dil_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    input  logic         sel_alt,
    input  logic         sel_repeat,
    input  logic         sel_negate,
    input  logic         sel_stuff,
    input  logic         sleep,
    output logic         take_input,
    output logic [W-1:0] ser_data,
    output logic         ser_second,
    output logic [W-1:0] lane_first,
    output logic [W-1:0] lane_second,
    output logic         lane_valid
);
    localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

    logic [NUM_MODES-1:0] sel_vec;
    mode_e                mode;
    logic [W-1:0]         cand_first;
    logic [W-1:0]         cand_second;
    phase_e               phase;
    logic                 capture;
    logic [W-1:0]         first_q;
    logic [W-1:0]         second_q;

    assign sel_vec = {sel_stuff, sel_negate, sel_repeat, sel_alt};

    dil_mode_decode u_decode (
        .sel  (sel_vec),
        .mode (mode)
    );

    dil_pair_gen #(.W(W)) u_pair (
        .a_word      (port_a),
        .b_word      (port_b),
        .mode        (mode),
        .first_word  (cand_first),
        .second_word (cand_second)
    );

    dil_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .phase   (phase),
        .capture (capture)
    );

    // Pair register: loads only on a boundary, so mid-pair changes never reach it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= MIDSCALE;
            second_q <= MIDSCALE;
        end else if (capture) begin
            first_q  <= cand_first;
            second_q <= cand_second;
        end
    end

    // Output process, decoded from the phase
    always_comb begin
        ser_data    = MIDSCALE;
        ser_second  = 1'b0;
        lane_first  = MIDSCALE;
        lane_second = MIDSCALE;
        lane_valid  = 1'b0;
        unique case (phase)
            PH_IDLE: begin
            end
            PH_FIRST: begin
                ser_data    = first_q;
                lane_first  = first_q;
                lane_second = second_q;
                lane_valid  = 1'b1;
            end
            PH_SECOND: begin
                ser_data    = second_q;
                ser_second  = 1'b1;
                lane_first  = first_q;
                lane_second = second_q;
                lane_valid  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign take_input = capture;
endmodule

// File: rtl/dil_checker.sv
`timescale 1ns/1ps
module dil_checker #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] port_a,
    input logic         sel_alt,
    input logic         sel_repeat,
    input logic         sel_negate,
    input logic         sel_stuff,
    input logic         take_input,
    input logic [W-1:0] ser_data,
    input logic         ser_second,
    input logic [W-1:0] lane_first,
    input logic [W-1:0] lane_second,
    input logic         lane_valid
);
    localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

    assert_first_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_input |=> (lane_valid && !ser_second));

    assert_second_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !ser_second) |=> (lane_valid && ser_second));

    assert_first_is_port_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_input |=> (lane_first == $past(port_a)));

    assert_repeat_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_input && sel_repeat && $countones({sel_alt, sel_repeat, sel_negate, sel_stuff}) == 1)
        |=> (lane_second == lane_first));

    assert_negate_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_input && sel_negate && $countones({sel_alt, sel_repeat, sel_negate, sel_stuff}) == 1)
        |=> (lane_second == ~lane_first));

    assert_stuff_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_input && sel_stuff && $countones({sel_alt, sel_repeat, sel_negate, sel_stuff}) == 1)
        |=> (lane_second == MIDSCALE));

    assert_pair_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !ser_second) |=> ($stable(lane_first) && $stable(lane_second)));

    assert_serial_matches_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |-> (ser_data == (ser_second ? lane_second : lane_first)));

    assert_idle_midscale_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid |-> (ser_data == MIDSCALE && lane_first == MIDSCALE && !ser_second));

    assert_no_load_mid_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !ser_second) |-> !take_input);
endmodule

bind dac_interleaver dil_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_a      (port_a),
    .sel_alt     (sel_alt),
    .sel_repeat  (sel_repeat),
    .sel_negate  (sel_negate),
    .sel_stuff   (sel_stuff),
    .take_input  (take_input),
    .ser_data    (ser_data),
    .ser_second  (ser_second),
    .lane_first  (lane_first),
    .lane_second (lane_second),
    .lane_valid  (lane_valid)
);

// File: tb/sim_dac_interleaver.sv
`timescale 1ns/1ps
module sim_dac_interleaver;
    localparam int W = 14;
    localparam logic [W-1:0] MID = 14'h2000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_a = '0;
    logic [W-1:0] port_b = '0;
    logic         sel_alt = 1'b0;
    logic         sel_repeat = 1'b0;
    logic         sel_negate = 1'b0;
    logic         sel_stuff = 1'b0;
    logic         sleep = 1'b0;
    logic         take_input;
    logic [W-1:0] ser_data;
    logic         ser_second;
    logic [W-1:0] lane_first;
    logic [W-1:0] lane_second;
    logic         lane_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_interleaver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b),
        .sel_alt(sel_alt), .sel_repeat(sel_repeat), .sel_negate(sel_negate),
        .sel_stuff(sel_stuff), .sleep(sleep), .take_input(take_input),
        .ser_data(ser_data), .ser_second(ser_second), .lane_first(lane_first),
        .lane_second(lane_second), .lane_valid(lane_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sels bit order: {stuff, negate, repeat, alt}
    function automatic logic [2*W-1:0] exp_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic [3:0] sels);
        logic [W-1:0] sec;
        sec = b;
        if ($countones(sels) == 1) begin
            if (sels[1]) sec = a;
            else if (sels[2]) sec = ~a;
            else if (sels[3]) sec = MID;
        end
        return {a, sec};
    endfunction

    function automatic string mode_tag(input logic [3:0] sels);
        if ($countones(sels) != 1) return "R6 fallback";
        if (sels[1]) return "R3 repeat";
        if (sels[2]) return "R4 negate";
        if (sels[3]) return "R5 stuff";
        return "R2 alternate";
    endfunction

    task automatic set_sels(input logic [3:0] s);
        {sel_stuff, sel_negate, sel_repeat, sel_alt} = s;
    endtask

    // Called at a negedge where a load is expected at the next rising edge
    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [3:0] sels, input bit sleep_mid);
        logic [2*W-1:0] e;
        string t;
        e = exp_pair(a, b, sels);
        t = mode_tag(sels);
        port_a = a; port_b = b; set_sels(sels);
        #1;
        chk("R11 take_input at boundary", take_input, 1);
        @(negedge clk);
        chk({t, " first word"}, ser_data, e[2*W-1:W]);
        chk("R7 phase flag first", ser_second, 0);
        chk({t, " lane_second"}, lane_second, e[W-1:0]);
        chk("R8 lane_valid first", lane_valid, 1);
        port_a = W'($urandom); port_b = W'($urandom); set_sels(4'($urandom));
        sleep = sleep_mid;
        #1;
        chk("R11 take_input mid-pair", take_input, 0);
        @(negedge clk);
        chk({t, " R9 second word"}, ser_data, e[W-1:0]);
        chk("R7 phase flag second", ser_second, 1);
        chk("R8 R9 lane_first held", lane_first, e[2*W-1:W]);
        chk("R8 lane_valid second", lane_valid, 1);
    endtask

    initial begin
        #(50000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 reset ser_data", ser_data, MID);
        chk("R1 reset lane_valid", lane_valid, 0);
        chk("R1 reset ser_second", ser_second, 0);
        rst_n = 1'b1;
        #1;
        chk("R1 after release lane_first", lane_first, MID);
        chk("R1 after release lane_second", lane_second, MID);

        // Directed corner cases
        run_pair(14'h1234, 14'h0ABC, 4'b0001, 1'b0);
        run_pair(14'h3FFF, 14'h0001, 4'b0010, 1'b0);   // R3: B ignored
        run_pair(14'h0000, 14'h1111, 4'b0100, 1'b0);   // R4: 0000 -> 3FFF
        run_pair(14'h2000, 14'h1111, 4'b0100, 1'b0);   // R4: 2000 -> 1FFF
        run_pair(14'h0155, 14'h3AAA, 4'b1000, 1'b0);   // R5
        run_pair(14'h0F0F, 14'h30F0, 4'b0000, 1'b0);   // R6 none high
        run_pair(14'h2222, 14'h3333, 4'b0110, 1'b0);   // R6 two high
        run_pair(14'h1357, 14'h2468, 4'b1111, 1'b0);   // R6 all high

        // R10: sleep raised mid-pair takes effect at the boundary
        run_pair(14'h0777, 14'h1888, 4'b0001, 1'b1);
        chk("R10 take_input low asleep", take_input, 0);
        for (int i = 0; i < 4; i++) begin
            port_a = W'($urandom); port_b = W'($urandom);
            @(negedge clk);
            chk("R10 asleep ser_data midscale", ser_data, MID);
            chk("R10 asleep lane_valid", lane_valid, 0);
            chk("R10 asleep lane_first", lane_first, MID);
        end
        sleep = 1'b0;
        run_pair(14'h0ACE, 14'h1BDF, 4'b0001, 1'b0);   // R10 resume

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [3:0] s;
            s = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'(1 << $urandom_range(0, 3));
            run_pair(W'($urandom), W'($urandom), s, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule